// File: doc/BRIEF.md
# Serial-Bus Register Target with 16-bit Auto-Incrementing Pointer

This block is an I2C target that lets a host reach an internal byte-wide register space with the same transaction shapes used for a serial memory that has two address bytes. It claims eight neighbouring 7-bit device addresses. A write transaction carries the device address, then the pointer high byte, then the pointer low byte, then any number of data bytes. For a read, the host sets the pointer with a write and then issues a repeated start with the read bit set. A read can also begin without a new pointer and continue from wherever the last transfer left off. The pointer moves up by one after every data byte in either direction. On the inside the block presents a plain register port: an address that always shows the pointer, a one-cycle write strobe with its data, and a read-data input that is taken when a byte is about to be shifted out.

Control is a single state machine.

**States:**
- IDLE: waits for a start.
- ADDR: receives the device byte.
- ADDR_ACK: acknowledges a matching device byte.
- PHI: receives the pointer high byte.
- PHI_ACK: acknowledges the pointer high byte.
- PLO: receives the pointer low byte.
- PLO_ACK: acknowledges the pointer low byte.
- WBYTE: receives a data byte.
- WBYTE_ACK: acknowledges a data byte.
- RBYTE: sends a data byte.
- RBYTE_CHK: samples the host acknowledge.

**Transitions:**
- A start detected in any state goes to ADDR.
- A stop detected in any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match. On a miss it goes to IDLE.
- ADDR_ACK goes to RBYTE when the read bit is set, and to PHI otherwise.
- PHI goes to PHI_ACK, then to PLO.
- PLO goes to PLO_ACK, then to WBYTE.
- WBYTE goes to WBYTE_ACK, then back to WBYTE.
- RBYTE goes to RBYTE_CHK.
- RBYTE_CHK goes back to RBYTE on an acknowledge, and to IDLE on a not-acknowledge.

Every move between receive, acknowledge and send states happens on an SCL falling edge.

Top module: `i2c_regbridge`

## Requirements
- R1: A device byte whose upper four address bits equal those of 0x28 is acknowledged, so any address 0x28 to 0x2F answers. Any other address gets no acknowledge, causes no register write, and leaves SDA released until the next start.
- R2: The first byte after a write-mode device byte loads the pointer's bits 15:8, and the second loads bits 7:0. After the second byte, `reg_addr` shows the new pointer.
- R3: Each data byte written by the host produces exactly one cycle of `reg_we`. During that cycle `reg_addr` holds the pointer and `reg_wdata` holds the byte, and the target acknowledges the byte.
- R4: The pointer increases by one after every data byte read or written, and wraps from 0xFFFF to 0x0000.
- R5: With the read bit set, the target sends `reg_rdata` for successive pointer values, most significant bit first. It starts at the current pointer, both after a repeated start and in a fresh transaction.
- R6: A not-acknowledge from the host after a read byte ends the read. The target then releases SDA, so later clocks read as all ones until a new start. The pointer has already moved past the byte that was not acknowledged.
- R7: A start condition in any state restarts the device-address phase. A stop returns the target to idle.
- R8: After reset, SDA is released, `reg_we` is low and the pointer is 0x0000.
- R9: The target changes its SDA drive only while SCL is low. Start and stop are recognised as SDA edges while SCL is high, after two-flop synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| reg_addr | output | ADDR_W | Register pointer |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Byte at `reg_addr` |

## Verification
The bench targets the pointer wrap at 0xFFFF. A design that carries into a seventeenth bit, or that increments before the write strobe, would write the wrong register. It probes both ends of the address window and the addresses just outside it. A loose match would acknowledge 0x27 or 0x30, and a tight one would ignore 0x2F. It ends a read with a not-acknowledge and keeps clocking. A target that keeps driving would return data where all ones are expected, and a pointer that skips the increment on the last byte would start the next read one register early. A repeated start is also sent in the middle of a pointer, which catches a design that keeps stale bit counts or half-loaded pointers.

// File: rtl/i2c_regbridge_pkg.sv
package i2c_regbridge_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PHI,
        ST_PHI_ACK,
        ST_PLO,
        ST_PLO_ACK,
        ST_WBYTE,
        ST_WBYTE_ACK,
        ST_RBYTE,
        ST_RBYTE_CHK
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Lines idle high, so the pipes reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edges while SCL stays high are bus conditions, not data.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_shift8.sv
module i2c_shift8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         sh_in,
    input  logic         bit_in,
    input  logic         sh_out,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld) begin
            q <= ld_val;
        end else if (sh_in) begin
            q <= {q[W-2:0], bit_in};
        end else if (sh_out) begin
            q <= {q[W-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic              inc,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] ptr
);

    localparam int HI_LSB = ADDR_W - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_hi) begin
            ptr[ADDR_W-1:HI_LSB] <= din;
        end else if (ld_lo) begin
            ptr[7:0] <= din;
        end else if (inc) begin
            ptr <= ptr + ADDR_W'(1);
        end
    end

    // R4: the all-ones pointer rolls over to zero
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_hi && !ld_lo && (&ptr)) |=> (ptr == '0));

endmodule

// File: rtl/i2c_regbridge.sv
module i2c_regbridge
    import i2c_regbridge_pkg::*;
#(
    parameter int         ADDR_W      = 16,
    parameter logic [6:0] DEV_BASE    = 7'h28,
    parameter int         LOOSE_BITS  = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);

    localparam int                BYTE_W   = 8;
    localparam int                CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    tgt_state_t          state, state_nx;
    logic [CNT_W-1:0]    bit_cnt;
    logic                host_nack;
    logic [BYTE_W-1:0]   shreg;
    logic                rx_state, tx_state, cnt_full, cnt_up, byte_end;
    logic                addr_hit, rd_mode;
    logic                sh_in, sh_load, sh_out;
    logic                ld_hi, ld_lo, ptr_inc;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rx_state = (state == ST_ADDR) || (state == ST_PHI) ||
                      (state == ST_PLO)  || (state == ST_WBYTE);
    assign tx_state = (state == ST_RBYTE);
    assign cnt_full = (bit_cnt == CNT_FULL);
    assign cnt_up   = scl_rise && !cnt_full && (rx_state || tx_state);
    assign byte_end = scl_fall && cnt_full && (rx_state || tx_state);
    assign addr_hit = (shreg[BYTE_W-1:1+LOOSE_BITS] == DEV_BASE[6:LOOSE_BITS]);
    assign rd_mode  = shreg[0];

    // Next-state decode
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_end) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rd_mode ? ST_RBYTE : ST_PHI;
                ST_PHI:       if (byte_end) state_nx = ST_PHI_ACK;
                ST_PHI_ACK:   if (scl_fall) state_nx = ST_PLO;
                ST_PLO:       if (byte_end) state_nx = ST_PLO_ACK;
                ST_PLO_ACK:   if (scl_fall) state_nx = ST_WBYTE;
                ST_WBYTE:     if (byte_end) state_nx = ST_WBYTE_ACK;
                ST_WBYTE_ACK: if (scl_fall) state_nx = ST_WBYTE;
                ST_RBYTE:     if (byte_end) state_nx = ST_RBYTE_CHK;
                ST_RBYTE_CHK: if (scl_fall) state_nx = host_nack ? ST_IDLE : ST_RBYTE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Bit counter, host acknowledge sample, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            host_nack <= 1'b0;
            reg_we    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else begin
                if (cnt_up)   bit_cnt <= bit_cnt + CNT_W'(1);
                if (byte_end) bit_cnt <= '0;
                if (byte_end && (state == ST_WBYTE)) reg_we <= 1'b1;
                if ((state == ST_RBYTE_CHK) && scl_rise) host_nack <= sda_s;
            end
        end
    end

    // Shift register and pointer controls
    assign sh_in   = rx_state && cnt_up && !start_det && !stop_det;
    assign sh_load = scl_fall && !start_det && !stop_det &&
                     (((state == ST_ADDR_ACK) && rd_mode) ||
                      ((state == ST_RBYTE_CHK) && !host_nack));
    assign sh_out  = tx_state && scl_fall && !cnt_full;
    assign ld_hi   = (state == ST_PHI) && byte_end && !start_det && !stop_det;
    assign ld_lo   = (state == ST_PLO) && byte_end && !start_det && !stop_det;
    // Writes step the pointer in the strobe cycle, reads as the byte ends.
    assign ptr_inc = reg_we || (tx_state && byte_end && !start_det && !stop_det);

    i2c_shift8 #(.W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (sh_load),
        .ld_val (reg_rdata),
        .sh_in  (sh_in),
        .bit_in (sda_s),
        .sh_out (sh_out),
        .q      (shreg)
    );

    i2c_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (ld_hi),
        .ld_lo (ld_lo),
        .inc   (ptr_inc),
        .din   (shreg),
        .ptr   (reg_addr)
    );

    assign reg_wdata = shreg;

    // Output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PHI_ACK, ST_PLO_ACK, ST_WBYTE_ACK: sda_oe = 1'b1;
            ST_RBYTE: sda_oe = ~shreg[BYTE_W-1];
            default:  sda_oe = 1'b0;
        endcase
    end

    // R3: the strobe lasts a single cycle
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: the strobe only follows a received data byte
    p_we_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(state) == ST_WBYTE));

    // R4: the pointer steps once per written byte
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + ADDR_W'(1)));

    // R7: a start always reopens the address phase
    p_start_to_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R9: the drive moves only while the synchronised SCL is low
    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R3: the bit counter never passes a full byte
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_FULL);

endmodule

// File: tb/test_i2c_regbridge.sv
`timescale 1ns/1ps
module test_i2c_regbridge;

    localparam int QT = 160;   // quarter of an SCL bit, 8 clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda_low = 1'b0;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic        reg_we;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    wire         sda_bus = !(m_sda_low || sda_oe);

    int n_chk = 0;
    int n_fail = 0;
    int r9_bad = 0;
    logic [15:0] exp_a[$];
    logic [7:0]  exp_d[$];

    always #10 clk = ~clk;

    function automatic logic [7:0] rd_pat(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    assign reg_rdata = rd_pat(reg_addr);

    i2c_regbridge i_i2c_regbridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference monitor: every clock, writes must match the expected queue.
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (exp_a.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", {reg_addr, 8'h00, reg_wdata}, 32'h0);
                end else begin
                    logic [15:0] ea;
                    logic [7:0]  ed;
                    ea = exp_a.pop_front();
                    ed = exp_d.pop_front();
                    chk((reg_addr == ea) && (reg_wdata == ed), "R3 write addr/data",
                        {reg_addr, 8'h00, reg_wdata}, {ea, 8'h00, ed});
                end
            end
            if ((sda_oe !== prev_oe) && m_scl) r9_bad++;
        end
        prev_oe = sda_oe;
    end

    task automatic tq;
        #(QT);
    endtask

    task automatic bus_start;
        m_sda_low = 1'b0; m_scl = 1'b1; tq;
        m_sda_low = 1'b1; tq;
        m_scl = 1'b0; tq;
    endtask

    task automatic bus_rstart;
        m_sda_low = 1'b0; tq;
        m_scl = 1'b1; tq;
        m_sda_low = 1'b1; tq;
        m_scl = 1'b0; tq;
    endtask

    task automatic bus_stop;
        m_sda_low = 1'b1; tq;
        m_scl = 1'b1; tq;
        m_sda_low = 1'b0; tq;
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; tq;
            m_scl = 1'b1; tq;
            m_scl = 1'b0; tq;
        end
        m_sda_low = 1'b0; tq;
        m_scl = 1'b1; tq;
        ack = !sda_bus;
        m_scl = 1'b0; tq;
    endtask

    task automatic get_byte(output logic [7:0] b, input bit ack_it);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tq;
            m_scl = 1'b1; tq;
            b[i] = sda_bus;
            m_scl = 1'b0;
        end
        tq;
        m_sda_low = ack_it; tq;
        m_scl = 1'b1; tq;
        m_scl = 1'b0; tq;
        m_sda_low = 1'b0;
    endtask

    task automatic wr_data(input logic [15:0] a, input logic [7:0] d, input string tag);
        bit ack;
        exp_a.push_back(a);
        exp_d.push_back(d);
        put_byte(d, ack);
        chk(ack, tag, {31'h0, ack}, 32'h1);
    endtask

    initial begin
        bit          ack;
        logic [7:0]  b;
        repeat (4) @(posedge clk);
        #5 rst_n = 1'b1;
        tq;
        // R8: reset state
        chk(!sda_oe, "R8 sda released", {31'h0, sda_oe}, 32'h0);
        chk(!reg_we, "R8 no write", {31'h0, reg_we}, 32'h0);
        chk(reg_addr == 16'h0, "R8 pointer zero", {16'h0, reg_addr}, 32'h0);

        // R1 R2 R3 R4: write stream at the low end of the window
        bus_start;
        put_byte({7'h28, 1'b0}, ack);
        chk(ack, "R1 ack 0x28", {31'h0, ack}, 32'h1);
        put_byte(8'h12, ack);
        chk(ack, "R2 ack ptr hi", {31'h0, ack}, 32'h1);
        put_byte(8'h34, ack);
        chk(ack, "R2 ack ptr lo", {31'h0, ack}, 32'h1);
        chk(reg_addr == 16'h1234, "R2 pointer loaded", {16'h0, reg_addr}, 32'h1234);
        wr_data(16'h1234, 8'hA1, "R3 ack data 0");
        wr_data(16'h1235, 8'hB2, "R3 ack data 1");
        wr_data(16'h1236, 8'hC3, "R3 ack data 2");
        bus_stop;
        chk(reg_addr == 16'h1237, "R4 pointer after stream", {16'h0, reg_addr}, 32'h1237);

        // R4: wrap at the top of the space, high end of the window
        bus_start;
        put_byte({7'h2F, 1'b0}, ack);
        chk(ack, "R1 ack 0x2F", {31'h0, ack}, 32'h1);
        put_byte(8'hFF, ack);
        put_byte(8'hFE, ack);
        wr_data(16'hFFFE, 8'h11, "R4 ack pre-wrap");
        wr_data(16'hFFFF, 8'h22, "R4 ack at top");
        wr_data(16'h0000, 8'h33, "R4 ack wrapped");
        bus_stop;
        chk(reg_addr == 16'h0001, "R4 pointer wrapped", {16'h0, reg_addr}, 32'h1);

        // R1: neighbours of the window are ignored
        bus_start;
        put_byte({7'h27, 1'b0}, ack);
        chk(!ack, "R1 no ack 0x27", {31'h0, ack}, 32'h0);
        put_byte(8'h00, ack);
        chk(!ack, "R1 silent after miss", {31'h0, ack}, 32'h0);
        bus_stop;
        bus_start;
        put_byte({7'h30, 1'b0}, ack);
        chk(!ack, "R1 no ack 0x30", {31'h0, ack}, 32'h0);
        bus_stop;
        chk(reg_addr == 16'h0001, "R1 pointer untouched", {16'h0, reg_addr}, 32'h1);

        // R5 R6: set pointer, repeated start, read four bytes
        bus_start;
        put_byte({7'h2B, 1'b0}, ack);
        put_byte(8'h40, ack);
        put_byte(8'h10, ack);
        bus_rstart;
        put_byte({7'h2B, 1'b1}, ack);
        chk(ack, "R5 ack read address", {31'h0, ack}, 32'h1);
        for (int k = 0; k < 4; k++) begin
            get_byte(b, k != 3);
            chk(b == rd_pat(16'h4010 + 16'(k)), "R5 read data", {24'h0, b},
                {24'h0, rd_pat(16'h4010 + 16'(k))});
        end
        chk(!sda_oe, "R6 released after nack", {31'h0, sda_oe}, 32'h0);
        get_byte(b, 1'b0);
        chk(b == 8'hFF, "R6 silent after nack", {24'h0, b}, 32'hFF);
        bus_stop;
        chk(reg_addr == 16'h4014, "R6 pointer past nacked byte", {16'h0, reg_addr}, 32'h4014);

        // R5: a fresh read continues from the pointer
        bus_start;
        put_byte({7'h2D, 1'b1}, ack);
        chk(ack, "R5 ack fresh read", {31'h0, ack}, 32'h1);
        get_byte(b, 1'b0);
        chk(b == rd_pat(16'h4014), "R5 continued read", {24'h0, b}, {24'h0, rd_pat(16'h4014)});
        bus_stop;

        // R7: repeated start in the middle of the pointer
        bus_start;
        put_byte({7'h2A, 1'b0}, ack);
        put_byte(8'h55, ack);
        bus_rstart;
        put_byte({7'h2A, 1'b0}, ack);
        chk(ack, "R7 ack after restart", {31'h0, ack}, 32'h1);
        put_byte(8'h00, ack);
        put_byte(8'h08, ack);
        wr_data(16'h0008, 8'h77, "R7 ack data after restart");
        bus_stop;
        chk(reg_addr == 16'h0009, "R7 pointer after restart", {16'h0, reg_addr}, 32'h9);

        tq;
        chk(exp_a.size() == 0, "R3 all writes seen", exp_a.size(), 32'h0);
        chk(r9_bad == 0, "R9 drive changed with SCL high", r9_bad, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(2_000_000);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule